// File: doc/BRIEF.md
# Six-Channel Multi-Mode Timer

This block is a bank of six 16-bit timer channels. Each channel has its own mode and its own count source. In auto-reload mode a channel counts up, reloads at overflow and raises its flag. In compare mode it toggles its output pin on every compare match. In PWM mode it produces a waveform whose period is set by the reload value and whose high time is set by the compare value. In capture mode it stores its running count when the trigger pin shows a rising edge.

Each channel counts on one of eight enable strobes. A prescaler outside the block supplies these strobes. On the two lowest channels, the top source selects a synchronized external clock pin in place of the eighth strobe. Software reaches the block through a single-cycle write port and a registered read port. A group run register lets any set of channels start or stop on the same clock edge. Per-channel sticky flags drive the interrupt outputs.

Top module: `mtimer_bank`

## Requirements
- R1: After reset, every counter, reload, compare and control register is zero, and so are the run register, all flags, all timer outputs and the interrupt outputs.
- R2: The address is {channel[2:0], reg[1:0]}. Channel registers are: 0 = control, 1 = reload, 2 = compare/capture, 3 = counter. The control register holds the mode in bits [1:0] (0 auto-reload, 1 compare, 2 PWM, 3 capture) and the source in bits [4:2]. Channel 6 is the group block: 0 = run (direct write), 1 = flags (write 1 to clear), 2 = start set, 3 = stop clear. Bit n of these belongs to channel n. Read data shows the addressed register one cycle after the address is presented.
- R3: A channel's counter increments by one on each cycle in which its run bit is set and its selected source strobe is high. A stopped channel holds its count.
- R4: When a counting cycle occurs at 0xFFFF, the counter loads the reload value instead. In auto-reload mode this overflow sets the channel flag.
- R5: In compare mode, the counting cycle that brings the counter to the compare value toggles the output and sets the flag.
- R6: In PWM mode, overflow drives the output high and sets the flag. The counting cycle that reaches the compare value drives the output low.
- R7: In capture mode, a rising edge on the trigger pin copies the counter into the compare/capture register and sets the flag on the third clock edge after the pin rises. A falling edge has no effect.
- R8: Source k selects strobe k. On channels 0 and 1, source 7 instead counts synchronized rising edges of that channel's external clock pin, and strobe 7 is ignored there.
- R9: A start-set write or a stop-clear write changes the run bits of every selected channel on the same edge and leaves the other run bits unchanged.
- R10: Flags are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it set. irq_o shows the flags.
- R11: In auto-reload and capture modes the timer output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 8 | Count enable strobes from the prescaler |
| ext_clk_i | input | 2 | External count clocks for channels 0 and 1 |
| trig_i | input | 6 | Capture trigger pins |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| tmr_o | output | 6 | Compare/PWM outputs |
| irq_o | output | 6 | Per-channel interrupt flags |

## Verification
Counter, output and flag changes caused by a strobe take effect on the edge that samples the strobe. The bench raises each strobe for one cycle at a falling edge and checks at the next falling edge. Read data takes one cycle after the address. A trigger edge reaches the flag and the capture register on the third rising edge after the pin changes, so the bench checks the flag low after two cycles and high after three. External clock pulses are held for three cycles each, and the count is read only after the synchronizer has settled.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  typedef enum logic [1:0] {
    MODE_RELOAD = 2'd0,
    MODE_CMP    = 2'd1,
    MODE_PWM    = 2'd2,
    MODE_CAPT   = 2'd3
  } tmr_mode_e;

  localparam logic [1:0] REG_CTRL   = 2'd0;
  localparam logic [1:0] REG_RELOAD = 2'd1;
  localparam logic [1:0] REG_CMP    = 2'd2;
  localparam logic [1:0] REG_CNT    = 2'd3;

  localparam logic [1:0] GRP_RUN   = 2'd0;
  localparam logic [1:0] GRP_FLAG  = 2'd1;
  localparam logic [1:0] GRP_START = 2'd2;
  localparam logic [1:0] GRP_STOP  = 2'd3;
endpackage

// File: rtl/mtimer_sync_edge.sv
module mtimer_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R7
  rise_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/mtimer_channel.sv
module mtimer_channel
  import mtimer_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SRC_W = 3,
  localparam int unsigned N_SRC = 1 << SRC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [N_SRC-1:0] src_tick_i,
  input  logic             trig_rise_i,
  input  logic             ctrl_wr_i,
  input  logic             reload_wr_i,
  input  logic             cmp_wr_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output tmr_mode_e        mode_o,
  output logic [SRC_W-1:0] src_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             out_o,
  output logic             evt_o
);
  tmr_mode_e        mode_q;
  logic [SRC_W-1:0] src_q;
  logic [CNT_W-1:0] cnt_q, reload_q, cmp_q, cnt_inc;
  logic             out_q, out_d;
  logic             tick, cnt_max, ovf, match, capt;

  assign tick    = run_i & src_tick_i[src_q];
  assign cnt_max = &cnt_q;
  assign ovf     = tick & cnt_max;
  assign cnt_inc = cnt_q + CNT_W'(1);
  assign match   = tick & ~cnt_max & (cnt_inc == cmp_q);
  assign capt    = (mode_q == MODE_CAPT) & trig_rise_i;

  always_comb begin
    out_d = 1'b0;
    evt_o = 1'b0;
    unique case (mode_q)
      MODE_RELOAD: evt_o = ovf;
      MODE_CMP: begin
        out_d = match ? ~out_q : out_q;
        evt_o = match;
      end
      MODE_PWM: begin
        out_d = ovf ? 1'b1 : (match ? 1'b0 : out_q);
        evt_o = ovf;
      end
      MODE_CAPT: evt_o = capt;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_RELOAD;
      src_q    <= '0;
      cnt_q    <= '0;
      reload_q <= '0;
      cmp_q    <= '0;
      out_q    <= 1'b0;
    end else begin
      if (ctrl_wr_i) begin
        mode_q <= tmr_mode_e'(wdata_i[1:0]);
        src_q  <= wdata_i[SRC_W+1:2];
      end
      if (reload_wr_i) reload_q <= wdata_i;
      if (cmp_wr_i)    cmp_q <= wdata_i;
      else if (capt)   cmp_q <= cnt_q;
      if (cnt_wr_i)    cnt_q <= wdata_i;
      else if (ovf)    cnt_q <= reload_q;
      else if (tick)   cnt_q <= cnt_inc;
      out_q <= out_d;
    end
  end

  assign mode_o   = mode_q;
  assign src_o    = src_q;
  assign cnt_o    = cnt_q;
  assign reload_o = reload_q;
  assign cmp_o    = cmp_q;
  assign out_o    = out_q;

  // R3
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr_i) |=> $stable(cnt_q));
  // R4
  ovf_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf && !cnt_wr_i) |=> (cnt_q == $past(reload_q)));
  // R6
  pwm_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_PWM && ovf) |=> out_q);
  // R7
  capt_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (capt && !cmp_wr_i) |=> (cmp_q == $past(cnt_q)));
  // R11
  out_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RELOAD || mode_q == MODE_CAPT) |=> !out_q);
endmodule

// File: rtl/mtimer_bank.sv
module mtimer_bank
  import mtimer_pkg::*;
#(
  parameter int unsigned N_CH        = 6,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned N_SRC       = 8,
  parameter int unsigned N_EXT       = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned SRC_W  = $clog2(N_SRC),
  localparam int unsigned CH_W   = $clog2(N_CH + 1),
  localparam int unsigned ADDR_W = CH_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  tick_i,
  input  logic [N_EXT-1:0]  ext_clk_i,
  input  logic [N_CH-1:0]   trig_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  output logic [N_CH-1:0]   tmr_o,
  output logic [N_CH-1:0]   irq_o
);
  logic [CH_W-1:0] sel_ch;
  logic [1:0]      sel_reg;
  logic            grp_wr;

  assign sel_ch  = addr_i[ADDR_W-1:2];
  assign sel_reg = addr_i[1:0];
  assign grp_wr  = we_i && (sel_ch == CH_W'(N_CH));

  logic [N_CH-1:0] run_q, flag_q, evt, trig_rise, flag_clr;
  logic [N_EXT-1:0] ext_rise;

  tmr_mode_e        mode_a   [N_CH];
  logic [SRC_W-1:0] src_a    [N_CH];
  logic [CNT_W-1:0] cnt_a    [N_CH];
  logic [CNT_W-1:0] reload_a [N_CH];
  logic [CNT_W-1:0] cmp_a    [N_CH];

  for (genvar e = 0; e < N_EXT; e++) begin : g_ext
    mtimer_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(ext_clk_i[e]),
      .rise_o (ext_rise[e])
    );
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [N_SRC-1:0] src_vec;
    logic             ch_wr;

    if (c < N_EXT) begin : g_ext_src
      assign src_vec = {ext_rise[c], tick_i[N_SRC-2:0]};
    end else begin : g_int_src
      assign src_vec = tick_i;
    end

    assign ch_wr = we_i && (sel_ch == CH_W'(c));

    mtimer_sync_edge #(.STAGES(SYNC_STAGES)) u_trig_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(trig_i[c]),
      .rise_o (trig_rise[c])
    );

    mtimer_channel #(.CNT_W(CNT_W), .SRC_W(SRC_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (run_q[c]),
      .src_tick_i (src_vec),
      .trig_rise_i(trig_rise[c]),
      .ctrl_wr_i  (ch_wr && sel_reg == REG_CTRL),
      .reload_wr_i(ch_wr && sel_reg == REG_RELOAD),
      .cmp_wr_i   (ch_wr && sel_reg == REG_CMP),
      .cnt_wr_i   (ch_wr && sel_reg == REG_CNT),
      .wdata_i    (wdata_i),
      .mode_o     (mode_a[c]),
      .src_o      (src_a[c]),
      .cnt_o      (cnt_a[c]),
      .reload_o   (reload_a[c]),
      .cmp_o      (cmp_a[c]),
      .out_o      (tmr_o[c]),
      .evt_o      (evt[c])
    );
  end

  assign flag_clr = (grp_wr && sel_reg == GRP_FLAG) ? wdata_i[N_CH-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (grp_wr) begin
        unique case (sel_reg)
          GRP_RUN:   run_q <= wdata_i[N_CH-1:0];
          GRP_START: run_q <= run_q | wdata_i[N_CH-1:0];
          GRP_STOP:  run_q <= run_q & ~wdata_i[N_CH-1:0];
          default: ;
        endcase
      end
      flag_q <= (flag_q & ~flag_clr) | evt;
    end
  end

  assign irq_o = flag_q;

  logic [CNT_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_ch == CH_W'(N_CH)) begin
      unique case (sel_reg)
        GRP_RUN:  rd_mux = CNT_W'(run_q);
        GRP_FLAG: rd_mux = CNT_W'(flag_q);
        default:  rd_mux = '0;
      endcase
    end
    for (int c = 0; c < N_CH; c++) begin
      if (sel_ch == CH_W'(c)) begin
        unique case (sel_reg)
          REG_CTRL:   rd_mux = CNT_W'({src_a[c], mode_a[c]});
          REG_RELOAD: rd_mux = reload_a[c];
          REG_CMP:    rd_mux = cmp_a[c];
          default:    rd_mux = cnt_a[c];
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_mux;
  end

  // R10
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grp_wr && sel_reg == GRP_FLAG) |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  // R9
  grp_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_wr && sel_reg == GRP_START)
      |=> ((run_q & $past(wdata_i[N_CH-1:0])) == $past(wdata_i[N_CH-1:0])));
  // R9
  grp_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp_wr && sel_reg == GRP_STOP)
      |=> ((run_q & $past(wdata_i[N_CH-1:0])) == '0));
endmodule

// File: tb/mtimer_bank_test.sv
module mtimer_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  tick = '0;
  logic [1:0]  ext_clk = '0;
  logic [5:0]  trig = '0;
  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [5:0]  tmr, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mtimer_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ext_clk_i(ext_clk),
    .trig_i(trig), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .tmr_o(tmr), .irq_o(irq)
  );

  function automatic logic [4:0] ra(int ch, int r);
    return {ch[2:0], r[1:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int ch, int r, logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = ra(ch, r); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int ch, int r, output logic [15:0] d);
    @(negedge clk);
    addr = ra(ch, r);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic pulse(int src, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick[src] = 1'b1;
      @(negedge clk);
      tick[src] = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(0, 0, d); check("R1 ctrl0", d, 0);
    rd(3, 3, d); check("R1 cnt3", d, 0);
    rd(5, 2, d); check("R1 cmp5", d, 0);
    rd(6, 0, d); check("R1 run", d, 0);
    rd(6, 1, d); check("R1 flags", d, 0);
    check("R1 tmr_o", tmr, 0);
    check("R1 irq_o", irq, 0);
  endtask

  task automatic t_group();
    logic [15:0] d;
    wr(6, 0, 0);
    wr(2, 0, 16'd12);
    wr(0, 3, 0); wr(1, 3, 0); wr(2, 3, 0);
    wr(6, 2, 16'h0007);
    pulse(0, 5);
    rd(0, 3, d); check("R3 ch0 count", d, 5);
    rd(1, 3, d); check("R9 ch1 started together", d, 5);
    rd(2, 3, d); check("R8 ch2 ignores strobe 0", d, 0);
    pulse(3, 2);
    rd(2, 3, d); check("R8 ch2 strobe 3", d, 2);
    wr(6, 3, 16'h0001);
    pulse(0, 3);
    rd(0, 3, d); check("R3 ch0 holds when stopped", d, 5);
    rd(1, 3, d); check("R9 ch1 keeps running", d, 8);
    rd(6, 0, d); check("R9 run bits", d, 16'h0006);
    rd(2, 0, d); check("R2 ctrl readback", d, 12);
  endtask

  task automatic t_reload();
    logic [15:0] d;
    wr(6, 0, 16'h0008);
    wr(3, 1, 16'hFFFC);
    wr(3, 3, 16'hFFFE);
    pulse(0, 1);
    check("R4 no flag before overflow", irq[3], 0);
    pulse(0, 1);
    check("R4 flag on overflow", irq[3], 1);
    rd(3, 3, d); check("R4 reload value", d, 16'hFFFC);
    pulse(0, 1);
    rd(3, 3, d); check("R4 counts after reload", d, 16'hFFFD);
    check("R10 flag sticky", irq[3], 1);
    check("R11 auto-reload output low", tmr[3], 0);
    wr(6, 1, 16'h0000);
    check("R10 write 0 keeps flag", irq[3], 1);
    wr(6, 1, 16'h0008);
    check("R10 write 1 clears flag", irq[3], 0);
  endtask

  task automatic t_compare();
    wr(6, 0, 16'h0010);
    wr(4, 0, 16'd1);
    wr(4, 1, 0); wr(4, 2, 16'd3); wr(4, 3, 0);
    pulse(0, 2);
    check("R5 before match", tmr[4], 0);
    pulse(0, 1);
    check("R5 toggle on match", tmr[4], 1);
    check("R5 flag on match", irq[4], 1);
    wr(6, 1, 16'h0010);
    wr(4, 3, 16'hFFFE);
    pulse(0, 2);
    check("R5 no flag at overflow", irq[4], 0);
    check("R5 output held", tmr[4], 1);
    pulse(0, 3);
    check("R5 second toggle", tmr[4], 0);
    check("R5 flag again", irq[4], 1);
    wr(6, 1, 16'h003F);
  endtask

  task automatic t_pwm();
    logic [15:0] d;
    wr(6, 0, 16'h0020);
    wr(5, 0, 16'd2);
    wr(5, 1, 16'hFFF0); wr(5, 2, 16'hFFF4); wr(5, 3, 16'hFFFE);
    pulse(0, 1);
    check("R6 low before overflow", tmr[5], 0);
    pulse(0, 1);
    check("R6 high at overflow", tmr[5], 1);
    check("R6 flag at overflow", irq[5], 1);
    pulse(0, 3);
    check("R6 high before match", tmr[5], 1);
    pulse(0, 1);
    check("R6 low at match", tmr[5], 0);
    pulse(0, 11);
    check("R6 low until overflow", tmr[5], 0);
    pulse(0, 1);
    check("R6 high again", tmr[5], 1);
    rd(5, 3, d); check("R6 period restart", d, 16'hFFF0);
    wr(6, 1, 16'h003F);
  endtask

  task automatic t_capture();
    logic [15:0] d;
    wr(6, 0, 0);
    wr(0, 0, 16'd3);
    wr(0, 3, 16'h1234);
    wr(6, 1, 16'h003F);
    @(negedge clk);
    trig[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7 not yet captured", irq[0], 0);
    @(negedge clk);
    check("R7 captured on third edge", irq[0], 1);
    rd(0, 2, d); check("R7 capture value", d, 16'h1234);
    check("R11 capture output low", tmr[0], 0);
    wr(0, 3, 16'h0055);
    wr(6, 1, 16'h0001);
    @(negedge clk);
    trig[0] = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 falling edge no flag", irq[0], 0);
    rd(0, 2, d); check("R7 falling edge keeps value", d, 16'h1234);
  endtask

  task automatic t_ext();
    logic [15:0] d;
    wr(6, 0, 16'h0006);
    wr(1, 0, 16'd28); wr(2, 0, 16'd28);
    wr(1, 3, 0); wr(2, 3, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ext_clk[1] = 1'b1;
      repeat (3) @(negedge clk);
      ext_clk[1] = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    rd(1, 3, d); check("R8 ch1 external count", d, 4);
    rd(2, 3, d); check("R8 ch2 no external", d, 0);
    pulse(7, 1);
    rd(1, 3, d); check("R8 ch1 ignores strobe 7", d, 4);
    rd(2, 3, d); check("R8 ch2 strobe 7", d, 1);
    wr(6, 0, 16'h0020);
    rd(6, 0, d); check("R2 run direct write", d, 16'h0020);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_group();
    t_reload();
    t_compare();
    t_pwm();
    t_capture();
    t_ext();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule